// File: doc/BRIEF.md
# Firmware-Upgrade Protocol State Machine

This block is the device side of a USB firmware-upgrade control protocol. A request decoder upstream presents one class request per cycle as a 3-bit code plus its length field. Requests with a zero length matter for download and upload. The block keeps the protocol state and a sticky status code. It answers status and state polls through a registered response port.

A memory engine beside it reports three things through level and pulse inputs: whether it is still busy with a block, when it has finished, and when it has failed. An image-complete level tells the block whether a zero-length download may start the manifest phase. A bus-reset pulse takes the device out of its two wait-for-reset states.

Packet handling, descriptors and flash access are outside this block.

Top module: `dfu_ctrl`

## Requirements
- R1: After reset the state is 2 (idle in upgrade mode), the status is 00h and no response is valid.
- R2: A download (code 1) with non-zero length in state 2 or 5 moves the state to 3 (download sync).
- R3: A status request (code 3) in state 3 moves to 4 (busy) when the memory engine is busy, otherwise to 5 (download idle). The response carries the state being entered. Its poll field is POLL_MS when that state is 4 or 7, and 0 otherwise.
- R4: In state 4 or 7, a memory error pulse enters state 10 with the engine's error code as status, or 0Eh when that code is 00h. A done pulse moves state 4 to 5.
- R5: A zero-length download in state 5 with image-complete high enters 6. A status request there enters 7, memory done then enters 8, and a bus reset in 8 enters 0.
- R6: A zero-length download in state 2, or in state 5 with image-complete low, enters state 10 with status 09h.
- R7: A request that the current state does not accept, including code 7, enters state 10 with status 0Fh. Any request in state 4 or 7 is unaccepted.
- R8: In state 10, every request other than clear-status leaves state and status unchanged. Status and state requests are still answered.
- R9: Clear-status (code 4) in state 10 moves to state 2 with status 00h.
- R10: Abort (code 6) in states 2, 5 and 9 moves to state 2 with status 00h.
- R11: A state request (code 5) returns the current state with the state-kind flag set and changes nothing. This holds in every state except 4, 7 and 8.
- R12: An upload (code 2) with non-zero length in state 2 or 9 leads to state 9. A zero-length upload there leads to state 2.
- R13: Detach (code 0) in state 0 enters 1, and a bus reset in state 1 enters 2.
- R14: In state 8, requests produce no response and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_code | input | 3 | Request code 0..6, 7 is illegal |
| req_len | input | LEN_W | Request length field |
| usb_reset | input | 1 | Bus reset seen (pulse) |
| mem_busy | input | 1 | Memory engine still working on a block |
| mem_done | input | 1 | Memory operation finished (pulse) |
| mem_err | input | 1 | Memory operation failed (pulse) |
| mem_err_code | input | 8 | Status code for the failure |
| img_done | input | 1 | All image data received |
| state | output | 4 | Current protocol state |
| status | output | 8 | Current status code |
| rsp_valid | output | 1 | Response valid (one cycle) |
| rsp_is_state | output | 1 | 1: state-only reply, 0: full status reply |
| rsp_status | output | 8 | Status field of the reply |
| rsp_poll_ms | output | POLL_W | Poll timeout field in ms |
| rsp_state | output | 4 | State field of the reply |
| rsp_istr | output | 8 | String index field |

## Verification
The bench targets the sticky error state. A design that let download or abort escape state 10 would be caught by R8, and one that kept an error code after clear-status would be caught by R9. It drives a zero-length download both with and without image-complete. Swapping those branches would leave the device in manifest sync when it should report 09h.

A memory error carrying code 00h must still report a failure. A design passing the raw code through would show status OK in state 10. Status polls in download sync are sent both with the engine busy and with it idle. A wrong next-state field or poll value in the reply would differ from the model there.

// File: rtl/dfu_ctrl_pkg.sv
package dfu_ctrl_pkg;
  localparam int STATE_W = 4;
  localparam int STS_W   = 8;
  localparam int CODE_W  = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_APP_IDLE   = 4'd0,
    ST_APP_DETACH = 4'd1,
    ST_IDLE       = 4'd2,
    ST_DN_SYNC    = 4'd3,
    ST_DN_BUSY    = 4'd4,
    ST_DN_IDLE    = 4'd5,
    ST_MF_SYNC    = 4'd6,
    ST_MF         = 4'd7,
    ST_MF_WAITRST = 4'd8,
    ST_UP_IDLE    = 4'd9,
    ST_ERROR      = 4'd10
  } dfu_state_e;

  localparam logic [CODE_W-1:0] RQ_DETACH   = 3'd0;
  localparam logic [CODE_W-1:0] RQ_DNLOAD   = 3'd1;
  localparam logic [CODE_W-1:0] RQ_UPLOAD   = 3'd2;
  localparam logic [CODE_W-1:0] RQ_GETSTAT  = 3'd3;
  localparam logic [CODE_W-1:0] RQ_CLRSTAT  = 3'd4;
  localparam logic [CODE_W-1:0] RQ_GETSTATE = 3'd5;
  localparam logic [CODE_W-1:0] RQ_ABORT    = 3'd6;

  localparam logic [STS_W-1:0] STS_OK      = 8'h00;
  localparam logic [STS_W-1:0] STS_NOTDONE = 8'h09;
  localparam logic [STS_W-1:0] STS_UNKNOWN = 8'h0E;
  localparam logic [STS_W-1:0] STS_STALL   = 8'h0F;

  typedef struct packed {
    logic any;
    logic det;
    logic dn;
    logic up;
    logic gstat;
    logic clr;
    logic gstate;
    logic abt;
    logic bad;
    logic zero;
  } req_dec_t;
endpackage

// File: rtl/dfu_rst_sync.sv
module dfu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dfu_req_decode.sv
module dfu_req_decode
  import dfu_ctrl_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [LEN_W-1:0]  req_len,
  output req_dec_t          dec
);
  localparam int NUM_CODES = 7;

  logic [NUM_CODES-1:0] hit;

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_hit
    assign hit[i] = req_valid && (req_code == CODE_W'(i));
  end

  always_comb begin
    dec        = '0;
    dec.any    = req_valid;
    dec.det    = hit[RQ_DETACH];
    dec.dn     = hit[RQ_DNLOAD];
    dec.up     = hit[RQ_UPLOAD];
    dec.gstat  = hit[RQ_GETSTAT];
    dec.clr    = hit[RQ_CLRSTAT];
    dec.gstate = hit[RQ_GETSTATE];
    dec.abt    = hit[RQ_ABORT];
    dec.bad    = req_valid && !(|hit);
    dec.zero   = (req_len == '0);
  end
endmodule

// File: rtl/dfu_fsm.sv
module dfu_fsm
  import dfu_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  req_dec_t         dec,
  input  logic             usb_reset,
  input  logic             mem_busy,
  input  logic             mem_done,
  input  logic             mem_err,
  input  logic [STS_W-1:0] mem_err_code,
  input  logic             img_done,
  output dfu_state_e       st_q,
  output dfu_state_e       st_d,
  output logic [STS_W-1:0] sts_q,
  output logic [STS_W-1:0] sts_d,
  output logic             gs_fire,
  output logic             gst_fire
);
  logic stall;
  logic mem_phase;

  assign mem_phase = (st_q == ST_DN_BUSY) || (st_q == ST_MF);

  always_comb begin
    st_d     = st_q;
    sts_d    = sts_q;
    gs_fire  = 1'b0;
    gst_fire = 1'b0;
    stall    = 1'b0;
    if (usb_reset && st_q == ST_APP_DETACH) begin
      st_d = ST_IDLE;
    end else if (usb_reset && st_q == ST_MF_WAITRST) begin
      st_d = ST_APP_IDLE;
    end else if (dec.any) begin
      if (st_q == ST_MF_WAITRST) begin
        st_d = st_q;
      end else if (st_q == ST_ERROR) begin
        if (dec.clr) begin
          st_d  = ST_IDLE;
          sts_d = STS_OK;
        end else if (dec.gstat) begin
          gs_fire = 1'b1;
        end else if (dec.gstate) begin
          gst_fire = 1'b1;
        end
      end else if (dec.gstate && !mem_phase) begin
        gst_fire = 1'b1;
      end else begin
        stall = 1'b1;
        case (st_q)
          ST_APP_IDLE: begin
            if (dec.det) begin
              st_d  = ST_APP_DETACH;
              stall = 1'b0;
            end else if (dec.gstat) begin
              gs_fire = 1'b1;
              stall   = 1'b0;
            end
          end
          ST_APP_DETACH: begin
            if (dec.gstat) begin
              gs_fire = 1'b1;
              stall   = 1'b0;
            end
          end
          ST_IDLE: begin
            stall = 1'b0;
            if (dec.dn) begin
              if (dec.zero) begin
                st_d  = ST_ERROR;
                sts_d = STS_NOTDONE;
              end else begin
                st_d = ST_DN_SYNC;
              end
            end else if (dec.up) begin
              st_d = dec.zero ? ST_IDLE : ST_UP_IDLE;
            end else if (dec.abt) begin
              sts_d = STS_OK;
            end else if (dec.gstat) begin
              gs_fire = 1'b1;
            end else begin
              stall = 1'b1;
            end
          end
          ST_DN_SYNC: begin
            if (dec.gstat) begin
              gs_fire = 1'b1;
              stall   = 1'b0;
              st_d    = mem_busy ? ST_DN_BUSY : ST_DN_IDLE;
            end
          end
          ST_DN_IDLE: begin
            stall = 1'b0;
            if (dec.dn) begin
              if (!dec.zero) begin
                st_d = ST_DN_SYNC;
              end else if (img_done) begin
                st_d = ST_MF_SYNC;
              end else begin
                st_d  = ST_ERROR;
                sts_d = STS_NOTDONE;
              end
            end else if (dec.abt) begin
              st_d  = ST_IDLE;
              sts_d = STS_OK;
            end else if (dec.gstat) begin
              gs_fire = 1'b1;
            end else begin
              stall = 1'b1;
            end
          end
          ST_MF_SYNC: begin
            if (dec.gstat) begin
              gs_fire = 1'b1;
              stall   = 1'b0;
              st_d    = ST_MF;
            end
          end
          ST_UP_IDLE: begin
            stall = 1'b0;
            if (dec.up) begin
              st_d = dec.zero ? ST_IDLE : ST_UP_IDLE;
            end else if (dec.abt) begin
              st_d  = ST_IDLE;
              sts_d = STS_OK;
            end else if (dec.gstat) begin
              gs_fire = 1'b1;
            end else begin
              stall = 1'b1;
            end
          end
          default: stall = 1'b1;
        endcase
        if (stall) begin
          st_d    = ST_ERROR;
          sts_d   = STS_STALL;
          gs_fire = 1'b0;
        end
      end
    end else if (mem_err && mem_phase) begin
      st_d  = ST_ERROR;
      sts_d = (mem_err_code == STS_OK) ? STS_UNKNOWN : mem_err_code;
    end else if (mem_done && mem_phase) begin
      st_d = (st_q == ST_DN_BUSY) ? ST_DN_IDLE : ST_MF_WAITRST;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sts_q <= STS_OK;
    end else begin
      st_q  <= st_d;
      sts_q <= sts_d;
    end
  end

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERROR && !dec.clr) |=> (st_q == ST_ERROR && $stable(sts_q)));

  p_clr_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ERROR && dec.clr && !usb_reset) |=> (st_q == ST_IDLE && sts_q == STS_OK));

  p_bad_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.bad && !usb_reset && st_q != ST_MF_WAITRST && st_q != ST_ERROR)
      |=> (st_q == ST_ERROR && sts_q == STS_STALL));

  p_waitrst_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MF_WAITRST && !usb_reset) |=> (st_q == ST_MF_WAITRST));

  p_sync_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DN_SYNC && dec.gstat && mem_busy && !usb_reset) |=> (st_q == ST_DN_BUSY));
endmodule

// File: rtl/dfu_resp.sv
module dfu_resp
  import dfu_ctrl_pkg::*;
#(
  parameter int                POLL_W  = 24,
  parameter logic [POLL_W-1:0] POLL_MS = 24'd5,
  parameter logic [STS_W-1:0]  ISTR    = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gs_fire,
  input  logic              gst_fire,
  input  dfu_state_e        st_q,
  input  dfu_state_e        st_d,
  input  logic [STS_W-1:0]  sts_d,
  output logic              rsp_valid,
  output logic              rsp_is_state,
  output logic [STS_W-1:0]  rsp_status,
  output logic [POLL_W-1:0] rsp_poll_ms,
  output logic [STATE_W-1:0] rsp_state,
  output logic [STS_W-1:0]  rsp_istr
);
  logic              load_en;
  logic              waits_d;
  logic [POLL_W-1:0] poll_d;

  assign load_en = gs_fire || gst_fire;
  assign waits_d = (st_d == ST_DN_BUSY) || (st_d == ST_MF);
  assign poll_d  = waits_d ? POLL_MS : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_is_state <= 1'b0;
      rsp_status   <= STS_OK;
      rsp_poll_ms  <= '0;
      rsp_state    <= ST_IDLE;
      rsp_istr     <= ISTR;
    end else begin
      rsp_valid <= load_en;
      if (load_en) begin
        rsp_is_state <= gst_fire;
        rsp_status   <= sts_d;
        rsp_poll_ms  <= gst_fire ? '0 : poll_d;
        rsp_state    <= gst_fire ? st_q : st_d;
        rsp_istr     <= ISTR;
      end
    end
  end

  p_busy_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_is_state && rsp_state == ST_DN_BUSY) |-> (rsp_poll_ms == POLL_MS));

  p_one_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gs_fire && gst_fire));
endmodule

// File: rtl/dfu_ctrl.sv
module dfu_ctrl
  import dfu_ctrl_pkg::*;
#(
  parameter int                LEN_W   = 16,
  parameter int                POLL_W  = 24,
  parameter logic [POLL_W-1:0] POLL_MS = 24'd5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [CODE_W-1:0]  req_code,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               usb_reset,
  input  logic               mem_busy,
  input  logic               mem_done,
  input  logic               mem_err,
  input  logic [STS_W-1:0]   mem_err_code,
  input  logic               img_done,
  output logic [STATE_W-1:0] state,
  output logic [STS_W-1:0]   status,
  output logic               rsp_valid,
  output logic               rsp_is_state,
  output logic [STS_W-1:0]   rsp_status,
  output logic [POLL_W-1:0]  rsp_poll_ms,
  output logic [STATE_W-1:0] rsp_state,
  output logic [STS_W-1:0]   rsp_istr
);
  logic             rst_sync_n;
  req_dec_t         dec;
  dfu_state_e       st_q;
  dfu_state_e       st_d;
  logic [STS_W-1:0] sts_q;
  logic [STS_W-1:0] sts_d;
  logic             gs_fire;
  logic             gst_fire;

  dfu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dfu_req_decode #(.LEN_W(LEN_W)) u_dec (
    .req_valid(req_valid), .req_code(req_code), .req_len(req_len), .dec(dec)
  );

  dfu_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .dec(dec), .usb_reset(usb_reset),
    .mem_busy(mem_busy), .mem_done(mem_done), .mem_err(mem_err),
    .mem_err_code(mem_err_code), .img_done(img_done),
    .st_q(st_q), .st_d(st_d), .sts_q(sts_q), .sts_d(sts_d),
    .gs_fire(gs_fire), .gst_fire(gst_fire)
  );

  dfu_resp #(.POLL_W(POLL_W), .POLL_MS(POLL_MS)) u_resp (
    .clk(clk), .rst_n(rst_sync_n), .gs_fire(gs_fire), .gst_fire(gst_fire),
    .st_q(st_q), .st_d(st_d), .sts_d(sts_d),
    .rsp_valid(rsp_valid), .rsp_is_state(rsp_is_state), .rsp_status(rsp_status),
    .rsp_poll_ms(rsp_poll_ms), .rsp_state(rsp_state), .rsp_istr(rsp_istr)
  );

  assign state  = st_q;
  assign status = sts_q;

  p_getstate_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_code == RQ_GETSTATE && !usb_reset &&
     state != 4'd4 && state != 4'd7 && state != 4'd8)
      |=> (rsp_valid && rsp_is_state && rsp_state == $past(state) && state == $past(state)));

  p_zero_dn_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_code == RQ_DNLOAD && req_len == '0 && !usb_reset && state == 4'd2)
      |=> (state == 4'd10 && status == STS_NOTDONE));
endmodule

// File: tb/sim_dfu_ctrl.sv
module sim_dfu_ctrl;
  localparam logic [23:0] POLL = 24'd5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, usb_reset, mem_busy, mem_done, mem_err, img_done;
  logic [2:0]  req_code;
  logic [15:0] req_len;
  logic [7:0]  mem_err_code;
  logic [3:0]  state, rsp_state;
  logic [7:0]  status, rsp_status, rsp_istr;
  logic        rsp_valid, rsp_is_state;
  logic [23:0] rsp_poll_ms;

  int checks = 0;
  int errors = 0;

  int          es;
  logic [7:0]  ests;
  bit          xrv, xis;
  int          xstate;
  logic [7:0]  xsts;
  logic [23:0] xpoll;

  always #10 clk = ~clk;

  dfu_ctrl #(.LEN_W(16), .POLL_W(24), .POLL_MS(POLL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .req_len(req_len), .usb_reset(usb_reset), .mem_busy(mem_busy),
    .mem_done(mem_done), .mem_err(mem_err), .mem_err_code(mem_err_code),
    .img_done(img_done), .state(state), .status(status), .rsp_valid(rsp_valid),
    .rsp_is_state(rsp_is_state), .rsp_status(rsp_status), .rsp_poll_ms(rsp_poll_ms),
    .rsp_state(rsp_state), .rsp_istr(rsp_istr)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Reference model built from the requirement list.
  task automatic model(input int kind, input logic [2:0] code, input logic [15:0] len,
                       input logic busy, input logic imgd, input logic [7:0] ec,
                       output string tag);
    int s = es;
    bit zero = (len == 16'd0);
    bit acc = 1'b0;
    bit gs = 1'b0;
    xrv = 1'b0; xis = 1'b0;
    tag = "R8";
    if (kind == 4) begin
      tag = "R13";
      if (s == 1) es = 2;
      else if (s == 8) begin es = 0; tag = "R5"; end
    end else if (kind == 2) begin
      tag = "R4";
      if (s == 4) es = 5;
      else if (s == 7) begin es = 8; tag = "R5"; end
    end else if (kind == 3) begin
      tag = "R4";
      if (s == 4 || s == 7) begin es = 10; ests = (ec == 8'h00) ? 8'h0E : ec; end
    end else if (kind == 1) begin
      if (s == 8) tag = "R14";
      else if (s == 10) begin
        tag = "R8";
        if (code == 3'd4) begin es = 2; ests = 8'h00; tag = "R9"; end
        else if (code == 3'd3) gs = 1'b1;
        else if (code == 3'd5) begin xrv = 1'b1; xis = 1'b1; xstate = s; end
      end else if (code == 3'd5 && s != 4 && s != 7) begin
        xrv = 1'b1; xis = 1'b1; xstate = s; tag = "R11";
      end else begin
        tag = "R3";
        if (code == 3'd3 && (s == 0 || s == 1 || s == 2 || s == 5 || s == 9)) begin
          acc = 1'b1; gs = 1'b1;
        end
        case (s)
          0: if (code == 3'd0) begin acc = 1'b1; es = 1; tag = "R13"; end
          2: begin
            if (code == 3'd1) begin
              acc = 1'b1;
              if (zero) begin es = 10; ests = 8'h09; tag = "R6"; end
              else begin es = 3; tag = "R2"; end
            end else if (code == 3'd2) begin acc = 1'b1; es = zero ? 2 : 9; tag = "R12"; end
            else if (code == 3'd6) begin acc = 1'b1; ests = 8'h00; tag = "R10"; end
          end
          3: if (code == 3'd3) begin acc = 1'b1; gs = 1'b1; es = busy ? 4 : 5; end
          5: begin
            if (code == 3'd1) begin
              acc = 1'b1;
              if (!zero) begin es = 3; tag = "R2"; end
              else if (imgd) begin es = 6; tag = "R5"; end
              else begin es = 10; ests = 8'h09; tag = "R6"; end
            end else if (code == 3'd6) begin acc = 1'b1; es = 2; ests = 8'h00; tag = "R10"; end
          end
          6: if (code == 3'd3) begin acc = 1'b1; gs = 1'b1; es = 7; tag = "R5"; end
          9: begin
            if (code == 3'd2) begin acc = 1'b1; es = zero ? 2 : 9; tag = "R12"; end
            else if (code == 3'd6) begin acc = 1'b1; es = 2; ests = 8'h00; tag = "R10"; end
          end
          default: ;
        endcase
        if (!acc) begin es = 10; ests = 8'h0F; gs = 1'b0; tag = "R7"; end
      end
    end else tag = "R1";
    if (gs) begin
      xrv = 1'b1; xis = 1'b0; xstate = es; xsts = ests;
      xpoll = (es == 4 || es == 7) ? POLL : 24'd0;
    end
  endtask

  task automatic step(input int kind, input logic [2:0] code, input logic [15:0] len,
                      input logic busy, input logic imgd, input logic [7:0] ec);
    string tag;
    req_valid    = (kind == 1);
    req_code     = code;
    req_len      = len;
    mem_done     = (kind == 2);
    mem_err      = (kind == 3);
    usb_reset    = (kind == 4);
    mem_busy     = busy;
    img_done     = imgd;
    mem_err_code = ec;
    model(kind, code, len, busy, imgd, ec, tag);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; mem_done = 1'b0; mem_err = 1'b0; usb_reset = 1'b0;
    chk(state == es[3:0], tag, "state", state, es);
    chk(status == ests, tag, "status", status, ests);
    chk(rsp_valid == xrv, tag, "rsp_valid", rsp_valid, xrv);
    if (xrv && rsp_valid) begin
      chk(rsp_is_state == xis, tag, "rsp_is_state", rsp_is_state, xis);
      chk(rsp_state == xstate[3:0], tag, "rsp_state", rsp_state, xstate);
      if (!xis) begin
        chk(rsp_status == xsts, tag, "rsp_status", rsp_status, xsts);
        chk(rsp_poll_ms == xpoll, tag, "rsp_poll", rsp_poll_ms, xpoll);
        chk(rsp_istr == 8'h00, tag, "rsp_istr", rsp_istr, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finish");
    errors++; checks++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5EED_0042;
    void'($urandom(seed));
    rst_n = 1'b0; req_valid = 1'b0; req_code = '0; req_len = '0; usb_reset = 1'b0;
    mem_busy = 1'b0; mem_done = 1'b0; mem_err = 1'b0; mem_err_code = '0; img_done = 1'b0;
    es = 2; ests = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(state == 4'd2, "R1", "state", state, 2);
    chk(status == 8'h00, "R1", "status", status, 0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);

    // Directed walk through the corner cases
    step(1, 3'd1, 16'd64, 0, 0, 0);   // R2 download
    step(1, 3'd3, 16'd6, 1, 0, 0);    // R3 busy poll
    step(2, 3'd0, 16'd0, 0, 0, 0);    // R4 done
    step(1, 3'd1, 16'd0, 0, 0, 0);    // R6 not done
    step(1, 3'd3, 16'd6, 0, 0, 0);    // R8 status in error
    step(1, 3'd1, 16'd32, 0, 0, 0);   // R8 download ignored
    step(1, 3'd6, 16'd0, 0, 0, 0);    // R8 abort ignored
    step(1, 3'd4, 16'd0, 0, 0, 0);    // R9 clear
    step(1, 3'd1, 16'd32, 0, 0, 0);   // R2
    step(1, 3'd3, 16'd6, 0, 0, 0);    // R3 not busy
    step(1, 3'd1, 16'd0, 0, 1, 0);    // R5 manifest sync
    step(1, 3'd3, 16'd6, 0, 0, 0);    // R5 manifest, poll
    step(2, 3'd0, 16'd0, 0, 0, 0);    // R5 wait reset
    step(1, 3'd5, 16'd1, 0, 0, 0);    // R14 ignored
    step(4, 3'd0, 16'd0, 0, 0, 0);    // R5 to app idle
    step(1, 3'd0, 16'd0, 0, 0, 0);    // R13 detach
    step(4, 3'd0, 16'd0, 0, 0, 0);    // R13 bus reset
    step(1, 3'd2, 16'd16, 0, 0, 0);   // R12 upload
    step(1, 3'd5, 16'd1, 0, 0, 0);    // R11 get state
    step(1, 3'd6, 16'd0, 0, 0, 0);    // R10 abort
    step(1, 3'd7, 16'd0, 0, 0, 0);    // R7 illegal code
    step(1, 3'd4, 16'd0, 0, 0, 0);    // R9
    step(1, 3'd1, 16'd8, 0, 0, 0);
    step(1, 3'd3, 16'd6, 1, 0, 0);
    step(1, 3'd5, 16'd1, 0, 0, 0);    // R7 request while busy
    step(1, 3'd4, 16'd0, 0, 0, 0);
    step(1, 3'd1, 16'd8, 0, 0, 0);
    step(1, 3'd3, 16'd6, 1, 0, 0);
    step(3, 3'd0, 16'd0, 0, 0, 8'h00); // R4 code 0 becomes 0Eh
    step(1, 3'd4, 16'd0, 0, 0, 0);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      int kind = (r < 60) ? 1 : (r < 75) ? 2 : (r < 85) ? 3 : (r < 90) ? 4 : 0;
      logic [2:0]  c  = 3'($urandom_range(0, 7));
      logic [15:0] l  = ($urandom_range(0, 3) == 0) ? 16'd0 : 16'($urandom_range(1, 512));
      logic        b  = 1'($urandom_range(0, 1));
      logic        im = 1'($urandom_range(0, 1));
      logic [7:0]  ec = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(1, 15));
      step(kind, c, l, b, im, ec);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule